// File: doc/BRIEF.md
# Single-Frame Ethernet Host Buffer

This block is the register and buffer front end between a host bus and a simple Ethernet MAC. It moves one frame at a time in each direction. On the receive side, the MAC delivers a byte stream. The block packs it into 32-bit words, holds the whole frame, and reports it through a receive status register. The host then drains the words from a receive data address and acknowledges the frame. On the transmit side, the host pushes words into a transmit data address, then writes a start bit and the byte length. The block streams exactly that many bytes to the MAC and reports completion.

A single interrupt line combines two causes, each with its own enable bit. The receive cause is a level: it follows the frame-pending flag. The transmit cause is a one-cycle pulse raised when a transmission finishes. A completion that happens while the transmit cause is masked is therefore not seen later. Reads have one cycle of latency: `bus_rdata` holds the value on the cycle after `bus_rd`.

The word addresses on `bus_addr` are:

- 0: transmit data, write only.
- 1: transmit control.
- 2: receive data, read only.
- 3: receive status.
- 4: interrupt enable.

Top module: `eth_hostbuf`

## Requirements
- R1: After reset, the receive status, transmit control and interrupt enable registers read 0. `irq` is 0, `mrx_ready` is 1 and `mtx_valid` is 0.
- R2: Received bytes are packed big-endian: frame byte 0 goes to bits 31:24 of the first word. Unused bytes of the last word read as zero. The frame is read in order from address 2, one word per read, ceil(length/4) reads in all.
- R3: When the byte marked last is accepted, the receive status register (address 3) updates as follows. Bit 31 (frame pending) sets. Bit 30 takes the error strobe and bit 29 takes the CRC-error strobe, both as sampled with the last byte. Bits 15:0 hold the byte count.
- R4: Bit 28 of the receive status register sets when the frame is shorter than 60 bytes.
- R5: While a frame is pending, `mrx_ready` is 0 and no new byte is taken. Any write to address 3 acknowledges the frame, clears the whole register to 0 and raises `mrx_ready` again.
- R6: Writing address 1 with bit 31 set and a nonzero length in bits 15:0 starts a transmission. While in flight, address 1 reads bit 31 = 1 with the length in bits 15:0. The stream carries exactly that many bytes, big-endian from the pushed words, with `mtx_last` on the final byte.
- R7: On completion, bit 31 of address 1 clears. Bit 30 takes `mtx_err` as sampled with the last byte, and bits 15:0 keep the byte count. A write to address 1 with bit 31 clear, while idle, zeroes the register.
- R8: Writes to address 0 or address 1 while a transmission is in flight have no effect.
- R9: In the interrupt enable register (address 4), bit 0 enables the receive cause and bit 1 the transmit cause. `irq` is high while bit 0 is set and a frame is pending. Writing 0 masks both causes.
- R10: With bit 1 of address 4 set, `irq` pulses for exactly one cycle after each transmission completes. A completion that occurs while bit 1 is clear gives no interrupt when bit 1 is set later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 3 | Host word address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Combined interrupt |
| mrx_valid | input | 1 | Receive byte valid from MAC |
| mrx_data | input | 8 | Receive byte |
| mrx_last | input | 1 | Marks the final byte of a frame |
| mrx_err | input | 1 | Receive error, sampled with the last byte |
| mrx_crc_err | input | 1 | CRC error, sampled with the last byte |
| mrx_ready | output | 1 | Block accepts a receive byte |
| mtx_valid | output | 1 | Transmit byte valid |
| mtx_data | output | 8 | Transmit byte |
| mtx_last | output | 1 | Marks the final transmit byte |
| mtx_ready | input | 1 | MAC accepts a transmit byte |
| mtx_err | input | 1 | Transmit error, sampled with the last byte |

## Verification
The bench builds the block with its default parameters: a 1536-byte frame limit, which gives 384-word buffers, and a 16-bit length field. These values make a maximum-size received frame reachable, which fills the receive buffer exactly to its last word. Short frames exercise the length-error flag and the zero padding of a partial last word. Transmit lengths that are not a multiple of four show that the padding bytes of the final word are dropped from the stream.

// File: rtl/ehb_pkg.sv
// Shared register addresses and status-bit positions of the host buffer.
// Assumes a word-addressed host bus with a 3-bit address.
package ehb_pkg;
    localparam int ADDR_W    = 3;
    localparam int BIT_BUSY  = 31;
    localparam int BIT_FLAG  = 31;
    localparam int BIT_ERR   = 30;
    localparam int BIT_CRC   = 29;
    localparam int BIT_SHORT = 28;
    localparam int MIN_FRAME = 60;

    typedef enum logic [ADDR_W-1:0] {
        A_TXDATA = 3'd0,
        A_TXCTRL = 3'd1,
        A_RXDATA = 3'd2,
        A_RXCTRL = 3'd3,
        A_IRQEN  = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/word_fifo.sv
// Word FIFO with show-ahead read data.
// Assumes the user never pushes when full. A pop when empty is ignored.
module word_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 384
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [AW:0]      count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    // Storage write, no reset needed for data.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
endmodule

// File: rtl/rx_pack.sv
// Packs the receive byte stream into big-endian words and latches frame status.
// Assumes the MAC never sends more bytes than the buffer holds.
module rx_pack
    import ehb_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             in_last,
    input  logic             in_err,
    input  logic             in_crc,
    input  logic             ack,
    output logic             in_ready,
    output logic             push,
    output logic [31:0]      push_word,
    output logic             pend,
    output logic             st_err,
    output logic             st_crc,
    output logic             st_short,
    output logic [LEN_W-1:0] st_len
);
    logic [31:0]      acc;
    logic [1:0]       idx;
    logic [LEN_W-1:0] cnt;
    logic             fire;

    assign in_ready  = !pend;
    assign fire      = in_valid && in_ready;
    assign push_word = acc | ({24'd0, in_byte} << {~idx, 3'b000});
    assign push      = fire && ((idx == 2'd3) || in_last);

    // Byte accumulation and end-of-frame status capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0; idx <= '0; cnt <= '0;
            pend <= 1'b0; st_err <= 1'b0; st_crc <= 1'b0;
            st_short <= 1'b0; st_len <= '0;
        end else begin
            if (ack) begin
                pend <= 1'b0; st_err <= 1'b0; st_crc <= 1'b0;
                st_short <= 1'b0; st_len <= '0;
            end
            if (fire) begin
                acc <= push ? '0 : push_word;
                idx <= idx + 1'b1;
                cnt <= cnt + 1'b1;
                if (in_last) begin
                    idx      <= '0;
                    cnt      <= '0;
                    pend     <= 1'b1;
                    st_err   <= in_err;
                    st_crc   <= in_crc;
                    st_len   <= cnt + 1'b1;
                    st_short <= (cnt + 1'b1) < LEN_W'(MIN_FRAME);
                end
            end
        end
    end

    assert_flag_from_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(in_valid && in_last));
endmodule

// File: rtl/tx_unpack.sv
// Streams a programmed number of bytes out of buffered big-endian words.
// Pops each word after its fourth byte or after the final byte, dropping padding.
module tx_unpack #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] start_len,
    input  logic [31:0]      word,
    input  logic             word_avail,
    input  logic             out_ready,
    output logic             pop,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             out_last,
    output logic             busy,
    output logic             done
);
    logic [LEN_W-1:0] len_q, cnt;
    logic [1:0]       idx;
    logic             fire;

    assign out_valid = busy && word_avail;
    assign out_byte  = word[{~idx, 3'b000} +: 8];
    assign out_last  = (cnt == len_q - 1'b1);
    assign fire      = out_valid && out_ready;
    assign pop       = fire && ((idx == 2'd3) || out_last);
    assign done      = fire && out_last;

    // Frame progress: start, per-byte advance, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; len_q <= '0; cnt <= '0; idx <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1; len_q <= start_len; cnt <= '0; idx <= '0;
        end else if (fire) begin
            cnt <= cnt + 1'b1;
            idx <= idx + 1'b1;
            if (out_last) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/eth_hostbuf.sv
// Host register file and buffers for one receive and one transmit frame.
// Assumes at most one of bus_wr / bus_rd per cycle and frames within MAX_FRAME_BYTES.
module eth_hostbuf
    import ehb_pkg::*;
#(
    parameter int MAX_FRAME_BYTES = 1536,
    parameter int LEN_W           = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    input  logic              mrx_valid,
    input  logic [7:0]        mrx_data,
    input  logic              mrx_last,
    input  logic              mrx_err,
    input  logic              mrx_crc_err,
    output logic              mrx_ready,
    output logic              mtx_valid,
    output logic [7:0]        mtx_data,
    output logic              mtx_last,
    input  logic              mtx_ready,
    input  logic              mtx_err
);
    localparam int BUF_WORDS = (MAX_FRAME_BYTES + 3) / 4;

    logic             rx_push, rx_pop, rx_empty, rx_full, rx_ack;
    logic [31:0]      rx_word, rx_head;
    logic             rx_pend, rx_err_q, rx_crc_q, rx_short_q;
    logic [LEN_W-1:0] rx_len_q;
    logic             tx_push, tx_pop, tx_empty, tx_full, tx_start, tx_ctl_wr;
    logic [31:0]      tx_head;
    logic             tx_busy, tx_done, tx_err_q, done_pulse;
    logic [LEN_W-1:0] tx_len_q;
    logic [1:0]       irq_en;
    logic [31:0]      rd_mux;

    assign tx_push   = bus_wr && (bus_addr == A_TXDATA) && !tx_busy;
    assign tx_ctl_wr = bus_wr && (bus_addr == A_TXCTRL) && !tx_busy;
    assign tx_start  = tx_ctl_wr && bus_wdata[BIT_BUSY] && (bus_wdata[LEN_W-1:0] != '0);
    assign rx_pop    = bus_rd && (bus_addr == A_RXDATA);
    assign rx_ack    = bus_wr && (bus_addr == A_RXCTRL);

    word_fifo #(.WIDTH(32), .DEPTH(BUF_WORDS)) i_rx_buf (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_word),
        .pop(rx_pop), .head(rx_head), .empty(rx_empty), .full(rx_full));

    word_fifo #(.WIDTH(32), .DEPTH(BUF_WORDS)) i_tx_buf (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .push_data(bus_wdata),
        .pop(tx_pop), .head(tx_head), .empty(tx_empty), .full(tx_full));

    rx_pack #(.LEN_W(LEN_W)) i_rx_pack (
        .clk(clk), .rst_n(rst_n), .in_valid(mrx_valid), .in_byte(mrx_data),
        .in_last(mrx_last), .in_err(mrx_err), .in_crc(mrx_crc_err), .ack(rx_ack),
        .in_ready(mrx_ready), .push(rx_push), .push_word(rx_word), .pend(rx_pend),
        .st_err(rx_err_q), .st_crc(rx_crc_q), .st_short(rx_short_q), .st_len(rx_len_q));

    tx_unpack #(.LEN_W(LEN_W)) i_tx_unpack (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .start_len(bus_wdata[LEN_W-1:0]),
        .word(tx_head), .word_avail(!tx_empty), .out_ready(mtx_ready), .pop(tx_pop),
        .out_valid(mtx_valid), .out_byte(mtx_data), .out_last(mtx_last),
        .busy(tx_busy), .done(tx_done));

    // Transmit status register, completion pulse and interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_err_q <= 1'b0; tx_len_q <= '0; done_pulse <= 1'b0; irq_en <= '0;
        end else begin
            done_pulse <= tx_done;
            if (tx_ctl_wr) begin
                tx_err_q <= 1'b0;
                tx_len_q <= tx_start ? bus_wdata[LEN_W-1:0] : '0;
            end
            if (tx_done) tx_err_q <= mtx_err;
            if (bus_wr && (bus_addr == A_IRQEN)) irq_en <= bus_wdata[1:0];
        end
    end

    // Read data selection by address.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_TXCTRL: begin
                rd_mux[BIT_BUSY]    = tx_busy;
                rd_mux[BIT_ERR]     = tx_err_q;
                rd_mux[LEN_W-1:0]   = tx_len_q;
            end
            A_RXDATA: rd_mux = rx_empty ? '0 : rx_head;
            A_RXCTRL: begin
                rd_mux[BIT_FLAG]    = rx_pend;
                rd_mux[BIT_ERR]     = rx_err_q;
                rd_mux[BIT_CRC]     = rx_crc_q;
                rd_mux[BIT_SHORT]   = rx_short_q;
                rd_mux[LEN_W-1:0]   = rx_len_q;
            end
            A_IRQEN: rd_mux[1:0] = irq_en;
            default: rd_mux = '0;
        endcase
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign irq = (irq_en[0] && rx_pend) || (irq_en[1] && done_pulse);

    assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> $past(mtx_valid && mtx_ready && mtx_last));
    assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (!tx_busy && $past(tx_busy)));
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rx_pend || done_pulse));
    assert_no_full_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !(mrx_valid && mrx_ready && !mrx_last));
endmodule

// File: tb/test_eth_hostbuf.sv
module test_eth_hostbuf;
    logic        clk = 0, rst_n = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [2:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        irq;
    logic        mrx_valid = 0, mrx_last = 0, mrx_err = 0, mrx_crc_err = 0, mrx_ready;
    logic [7:0]  mrx_data = 0;
    logic        mtx_valid, mtx_last, mtx_ready = 0, mtx_err = 0;
    logic [7:0]  mtx_data;

    int n_chk = 0, n_fail = 0, ncap = 0, irq_hits = 0;
    logic [7:0] cap [0:63];
    logic       cap_last [0:63];

    always #2 clk = ~clk;

    eth_hostbuf i_eth_hostbuf (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .mrx_valid(mrx_valid), .mrx_data(mrx_data), .mrx_last(mrx_last),
        .mrx_err(mrx_err), .mrx_crc_err(mrx_crc_err), .mrx_ready(mrx_ready),
        .mtx_valid(mtx_valid), .mtx_data(mtx_data), .mtx_last(mtx_last),
        .mtx_ready(mtx_ready), .mtx_err(mtx_err));

    // Transmit sink and interrupt monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (mtx_valid && mtx_ready && ncap < 64) begin
            cap[ncap] = mtx_data;
            cap_last[ncap] = mtx_last;
            ncap++;
        end
        if (irq) irq_hits++;
    end

    function automatic logic [7:0] pat(input logic [7:0] s, input int i);
        return s + 8'(i * 7);
    endfunction

    function automatic logic [31:0] exp_word(input logic [7:0] s, input int len, input int k);
        logic [31:0] w = '0;
        for (int b = 0; b < 4; b++)
            if (4*k + b < len) w[31-8*b -: 8] = pat(s, 4*k + b);
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic brd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1;
        @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    task automatic rx_send(input int len, input logic [7:0] s, input logic e, input logic c);
        @(negedge clk);
        for (int i = 0; i < len; i++) begin
            while (!mrx_ready) @(negedge clk);
            mrx_valid = 1; mrx_data = pat(s, i); mrx_last = (i == len-1);
            mrx_err = e; mrx_crc_err = c;
            @(negedge clk);
        end
        mrx_valid = 0; mrx_last = 0; mrx_err = 0; mrx_crc_err = 0;
    endtask

    task automatic rx_drain(input int len, input logic [7:0] s, input string req);
        logic [31:0] d;
        for (int k = 0; k < (len+3)/4; k++) begin
            brd(3'd2, d);
            chk(req, d, exp_word(s, len, k));
        end
    endtask

    task automatic set_tx_pins(input logic rdy, input logic e);
        @(posedge clk); #1 mtx_ready = rdy; mtx_err = e;
    endtask

    task automatic tx_run(input int len, input logic [7:0] s, input logic e, input logic poke);
        logic [31:0] d;
        int bad = 0;
        set_tx_pins(0, 0);
        for (int w = 0; w < (len+3)/4; w++) bwr(3'd0, exp_word(s, 4*((len+3)/4), w));
        ncap = 0;
        bwr(3'd1, 32'h8000_0000 | len);
        brd(3'd1, d);
        chk("R6 busy while in flight", d, 32'h8000_0000 | len);
        if (poke) begin
            bwr(3'd0, 32'hDEAD_BEEF);     // R8: ignored while busy
            bwr(3'd1, 32'h0000_0000);     // R8: ignored while busy
            brd(3'd1, d);
            chk("R8 control write ignored", d, 32'h8000_0000 | len);
        end
        set_tx_pins(1, e);
        for (int t = 0; t < 400 && ncap < len; t++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R6 byte count", ncap, len);
        for (int i = 0; i < len && i < 64; i++)
            if (cap[i] !== pat(s, i) || cap_last[i] !== (i == len-1)) bad++;
        chk("R6 byte order and last marker", bad, 0);
        chk("R8 nothing extra buffered", {31'd0, mtx_valid}, 0);
        brd(3'd1, d);
        chk("R7 completion status", d, ({31'd0, e} << 30) | len);
        bwr(3'd1, 32'h0);
        brd(3'd1, d);
        chk("R7 acknowledge clears", d, 0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        brd(3'd3, d); chk("R1 rx status", d, 0);
        brd(3'd1, d); chk("R1 tx control", d, 0);
        brd(3'd4, d); chk("R1 irq enable", d, 0);
        chk("R1 pins", {irq, mrx_ready, mtx_valid}, 3'b010);
    endtask

    task automatic t_rx_basic;
        logic [31:0] d;
        rx_send(64, 8'h10, 0, 0);
        brd(3'd3, d); chk("R3 status 64 bytes", d, 32'h8000_0040);
        @(negedge clk); mrx_valid = 1; mrx_data = 8'hAA;
        repeat (5) @(negedge clk);
        chk("R5 held off", {31'd0, mrx_ready}, 0);
        mrx_valid = 0;
        brd(3'd3, d); chk("R5 status unchanged", d, 32'h8000_0040);
        rx_drain(64, 8'h10, "R2 word 64");
        bwr(3'd3, 32'h0);
        brd(3'd3, d); chk("R5 acknowledge clears", d, 0);
        chk("R5 ready again", {31'd0, mrx_ready}, 1);
    endtask

    task automatic t_rx_odd;
        logic [31:0] d;
        rx_send(61, 8'h33, 0, 1);
        brd(3'd3, d); chk("R3 crc flag", d, 32'hA000_003D);
        rx_drain(61, 8'h33, "R2 padded word");
        bwr(3'd3, 32'h0);
    endtask

    task automatic t_rx_short;
        logic [31:0] d;
        rx_send(22, 8'h01, 1, 0);
        brd(3'd3, d); chk("R4 short frame", d, 32'hD000_0016);
        rx_drain(22, 8'h01, "R2 short frame word");
        bwr(3'd3, 32'h0);
    endtask

    task automatic t_rx_full;
        logic [31:0] d;
        rx_send(1536, 8'h5A, 0, 0);
        brd(3'd3, d); chk("R3 max frame", d, 32'h8000_0600);
        rx_drain(1536, 8'h5A, "R2 max frame word");
        bwr(3'd3, 32'h0);
    endtask

    task automatic t_irq_rx;
        logic [31:0] d;
        bwr(3'd4, 32'h1);
        rx_send(60, 8'h77, 0, 0);
        brd(3'd3, d); chk("R4 60 bytes not short", d, 32'h8000_003C);
        chk("R9 rx irq level", {31'd0, irq}, 1);
        bwr(3'd4, 32'h0);
        chk("R9 masked", {31'd0, irq}, 0);
        rx_drain(60, 8'h77, "R2 word 60");
        bwr(3'd3, 32'h0);
        bwr(3'd4, 32'h1);
        chk("R9 no irq without frame", {31'd0, irq}, 0);
        bwr(3'd4, 32'h0);
    endtask

    task automatic t_irq_tx;
        bwr(3'd4, 32'h2);
        irq_hits = 0;
        tx_run(8, 8'h21, 0, 0);
        chk("R10 one-cycle pulse", irq_hits, 1);
        bwr(3'd4, 32'h0);
        irq_hits = 0;
        tx_run(9, 8'h44, 0, 0);
        bwr(3'd4, 32'h2);
        repeat (5) @(negedge clk);
        chk("R10 masked completion lost", irq_hits, 0);
        bwr(3'd4, 32'h0);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_rx_basic();
        t_rx_odd();
        t_rx_short();
        t_rx_full();
        tx_run(17, 8'h90, 1, 1);
        tx_run(8, 8'h02, 0, 0);
        t_irq_rx();
        t_irq_tx();
        summary();
        $finish;
    end
endmodule